// File: doc/BRIEF.md
# Supply Monitor Status and Power-Down Control Register

This block is one 8-bit register on a microcontroller's peripheral bus. It collects two status flags that record events: a supply-warning flag, driven by a live comparator output, and a flag that records a return from partial power-down (stop2). It also holds four configuration bits. Two of them choose the high or low trip level for the detect comparator and the warning comparator. The other two decide whether the power controller may enter a deep power-down mode and, when it may, which mode it uses.

Software reads the register to find out what happened while it was not looking. It clears each flag by writing 1 to the flag's companion acknowledge bit. The mode bits accept one write after each reset and then hold their value. Three reset inputs identify the cause of a reset. A power-on reset clears everything. A brown-out reset or any other reset keeps the trip-level choices, so the comparators keep watching at the same thresholds while the chip restarts.

Top module: `pwr_stat_ctrl`

## Requirements
- R1: Register layout, from bit 7 down to bit 0: warning flag, warning acknowledge, detect trip select, warning trip select, stop2-exit flag, stop2-exit acknowledge, power-down enable, stop2 select. Both acknowledge bits always read 0.
- R2: The warning flag becomes 1 one clock after any cycle in which `warn_live_i` is high. It then stays 1 after `warn_live_i` falls.
- R3: Writing 1 to bit 6 clears the warning flag only when `warn_live_i` is low in that cycle. While `warn_live_i` is high, the write leaves the flag at 1.
- R4: After any of the three resets is released, the warning flag reads 1 one clock later if `warn_live_i` is high.
- R5: A one-cycle pulse on `stop2_exit_i` sets bit 3. Writing 1 to bit 2 clears it. When the pulse and the acknowledge arrive in the same cycle, the flag ends at 1.
- R6: The power-down enable bit (bit 1) takes its value from the first register write after a reset. Later writes do not change it until the next reset.
- R7: The stop2 select bit (bit 0) takes its value from that same first write and then holds it. `pd_stop2_o` is 1 only when both bit 1 and bit 0 are 1.
- R8: The trip selects (bit 5 drives `det_trip_hi_o`, bit 4 drives `warn_trip_hi_o`) can be written at any time. Power-on reset clears them. Brown-out reset and the other reset leave them unchanged.
- R9: Every bit other than the trip selects reads 0 after any reset.
- R10: A write while `sel_i` is low changes nothing, and `rdata_o` is 0 while `sel_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_lvd | input | 1 | Brown-out reset, synchronous, active high |
| rst_other | input | 1 | Any other reset, synchronous, active high |
| sel_i | input | 1 | Register selected by the address decode |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not selected |
| warn_live_i | input | 1 | Live warning comparator output, high when the supply is below the warning level |
| stop2_exit_i | input | 1 | One-cycle pulse when the chip returns from stop2 |
| det_trip_hi_o | output | 1 | Detect comparator uses the high trip level |
| warn_trip_hi_o | output | 1 | Warning comparator uses the high trip level |
| pd_enable_o | output | 1 | Deep power-down modes allowed |
| pd_stop2_o | output | 1 | Power-down uses stop2 (partial) and not stop1 |

## Verification
The hardest case to reach is a write that lands after a mode bit has locked. From the ports it looks just like the first write, so the bench runs a sweep. For each of the 16 combinations of trip and mode bits, it resets the block, writes the pattern, and then writes its complement. The bench checks that only the trip bits follow the complement. The warning-flag cases need the comparator input held high across the release of each reset type, and acknowledges issued both while the condition is present and after it has gone.

// File: rtl/pwr_stat_pkg.sv
package pwr_stat_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_WFLAG = 7;
  localparam int BIT_WACK  = 6;
  localparam int BIT_DSEL  = 5;
  localparam int BIT_WSEL  = 4;
  localparam int BIT_PFLAG = 3;
  localparam int BIT_PACK  = 2;
  localparam int BIT_PDEN  = 1;
  localparam int BIT_PSEL  = 0;
  localparam int N_ONCE    = 2;  // write-once bits occupy positions 0..N_ONCE-1
  localparam int N_TRIP    = 2;  // trip selects occupy BIT_WSEL..BIT_WSEL+N_TRIP-1
endpackage

// File: rtl/pwr_sticky_flag.sv
module pwr_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic ack_i,
  input  logic hold_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)                  flag_o <= 1'b0;
    else if (set_i)           flag_o <= 1'b1;
    else if (ack_i && !hold_i) flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);  // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !ack_i) |=> flag_o);  // R2
  AST_ACK_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (flag_o && hold_i) |=> flag_o);  // R3
endmodule

// File: rtl/pwr_once_bit.sv
module pwr_once_bit (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic d_i,
  output logic q_o
);
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o    <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_i && !lock_q) begin
      q_o    <= d_i;
      lock_q <= 1'b1;
    end
  end

  AST_ONCE_LOCK: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(q_o));  // R6
endmodule

// File: rtl/pwr_trip_bits.sv
module pwr_trip_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_por,
  input  logic         wr_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_trip
    always_ff @(posedge clk) begin
      if (rst_por)   q_o[g] <= 1'b0;
      else if (wr_i) q_o[g] <= d_i[g];
    end
  end
endmodule

// File: rtl/pwr_stat_ctrl.sv
module pwr_stat_ctrl
  import pwr_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_por,
  input  logic             rst_lvd,
  input  logic             rst_other,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             warn_live_i,
  input  logic             stop2_exit_i,
  output logic             det_trip_hi_o,
  output logic             warn_trip_hi_o,
  output logic             pd_enable_o,
  output logic             pd_stop2_o
);
  logic              rst_any;
  logic              wr_hit;
  logic              warn_flag;
  logic              pdx_flag;
  logic [N_ONCE-1:0] once_q;
  logic [N_TRIP-1:0] trip_q;
  logic              unused_wbits;

  assign rst_any      = rst_por | rst_lvd | rst_other;
  assign wr_hit       = sel_i & wr_i;
  assign unused_wbits = ^{wdata_i[BIT_WFLAG], wdata_i[BIT_PFLAG]};

  pwr_sticky_flag u_warn_flag (
    .clk    (clk),
    .rst    (rst_any),
    .set_i  (warn_live_i),
    .ack_i  (wr_hit & wdata_i[BIT_WACK]),
    .hold_i (warn_live_i),
    .flag_o (warn_flag)
  );

  pwr_sticky_flag u_pdx_flag (
    .clk    (clk),
    .rst    (rst_any),
    .set_i  (stop2_exit_i),
    .ack_i  (wr_hit & wdata_i[BIT_PACK]),
    .hold_i (1'b0),
    .flag_o (pdx_flag)
  );

  for (genvar g = 0; g < N_ONCE; g++) begin : g_once
    pwr_once_bit u_once (
      .clk  (clk),
      .rst  (rst_any),
      .wr_i (wr_hit),
      .d_i  (wdata_i[BIT_PSEL+g]),
      .q_o  (once_q[g])
    );
  end

  pwr_trip_bits #(.N(N_TRIP)) u_trip (
    .clk     (clk),
    .rst_por (rst_por),
    .wr_i    (wr_hit),
    .d_i     (wdata_i[BIT_WSEL +: N_TRIP]),
    .q_o     (trip_q)
  );

  assign det_trip_hi_o  = trip_q[BIT_DSEL-BIT_WSEL];
  assign warn_trip_hi_o = trip_q[0];
  assign pd_enable_o    = once_q[BIT_PDEN-BIT_PSEL];
  assign pd_stop2_o     = once_q[BIT_PDEN-BIT_PSEL] & once_q[0];

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      rdata_o[BIT_WFLAG]                = warn_flag;
      rdata_o[BIT_WSEL +: N_TRIP]       = trip_q;
      rdata_o[BIT_PFLAG]                = pdx_flag;
      rdata_o[BIT_PSEL +: N_ONCE]       = once_q;
    end
  end

  AST_TRIP_KEEP: assert property (@(posedge clk) disable iff (rst_por)
    (rst_lvd || rst_other) |=> $stable(trip_q));  // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst_any |=> (!pd_enable_o && !pd_stop2_o));  // R9
endmodule

// File: tb/pwr_stat_ctrl_bench.sv
module pwr_stat_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_por = 1'b1, rst_lvd = 1'b0, rst_other = 1'b0;
  logic       sel_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       warn_live_i = 1'b0, stop2_exit_i = 1'b0;
  logic       det_trip_hi_o, warn_trip_hi_o, pd_enable_o, pd_stop2_o;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_stat_ctrl u_pwr_stat_ctrl (
    .clk(clk), .rst_por(rst_por), .rst_lvd(rst_lvd), .rst_other(rst_other),
    .sel_i(sel_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .warn_live_i(warn_live_i), .stop2_exit_i(stop2_exit_i),
    .det_trip_hi_o(det_trip_hi_o), .warn_trip_hi_o(warn_trip_hi_o),
    .pd_enable_o(pd_enable_o), .pd_stop2_o(pd_stop2_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] mask, input logic [7:0] exp, input string what);
    logic [7:0] v;
    sel_i = 1'b1; wr_i = 1'b0;
    #1;
    v = rdata_o & mask;
    sel_i = 1'b0;
    chk(v, exp & mask, what);
  endtask

  task automatic wr(input logic [7:0] d);
    sel_i = 1'b1; wr_i = 1'b1; wdata_i = d;
    tick();
    sel_i = 1'b0; wr_i = 1'b0; wdata_i = 8'h00;
  endtask

  // kind: 0 power-on, 1 brown-out, 2 other
  task automatic do_reset(input int kind);
    rst_por = (kind == 0); rst_lvd = (kind == 1); rst_other = (kind == 2);
    tick();
    rst_por = 1'b0; rst_lvd = 1'b0; rst_other = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_por = 1'b0;
    // R9 reset state
    rd(8'hFF, 8'h00, "R9 power-on state");
    chk({4'h0, det_trip_hi_o, warn_trip_hi_o, pd_enable_o, pd_stop2_o}, 8'h00, "R9 outputs after power-on");

    // R1 R6 R7 R8 sweep: first write then complement
    for (int i = 0; i < 16; i++) begin
      logic [3:0] v;
      v = i[3:0];
      do_reset(2);
      wr({2'b11, v[3:2], 2'b11, v[1:0]});
      rd(8'hFF, {2'b00, v[3:2], 2'b00, v[1:0]}, "R1 layout and ack read 0");
      chk({6'h0, pd_enable_o, pd_stop2_o}, {6'h0, v[1], v[1] & v[0]}, "R7 mode outputs");
      chk({6'h0, det_trip_hi_o, warn_trip_hi_o}, {6'h0, v[3:2]}, "R8 trip outputs");
      wr({2'b00, ~v[3:2], 2'b00, ~v[1:0]});
      rd(8'h33, {2'b00, ~v[3:2], 2'b00, v[1:0]}, "R6 R7 second write ignored for mode bits");
      chk({6'h0, pd_enable_o, pd_stop2_o}, {6'h0, v[1], v[1] & v[0]}, "R6 mode outputs held");
    end

    // R4 warning flag right after each reset type
    for (int k = 0; k < 3; k++) begin
      warn_live_i = 1'b1;
      do_reset(k);
      tick();
      rd(8'h80, 8'h80, "R4 warning flag after reset");
    end
    // R3 ack blocked while condition present
    wr(8'h40);
    rd(8'h80, 8'h80, "R3 ack ignored while warning present");
    warn_live_i = 1'b0;
    tick(); tick();
    rd(8'h80, 8'h80, "R2 flag sticky after condition gone");
    wr(8'h40);
    rd(8'h80, 8'h00, "R3 ack clears when condition gone");
    warn_live_i = 1'b1; tick(); warn_live_i = 1'b0;
    rd(8'h80, 8'h80, "R2 single-cycle warning sets flag");
    wr(8'h40);
    rd(8'h80, 8'h00, "R3 clear again");

    // R5 stop2 exit flag
    stop2_exit_i = 1'b1; tick(); stop2_exit_i = 1'b0;
    rd(8'h08, 8'h08, "R5 stop2 exit sets flag");
    wr(8'h04);
    rd(8'h08, 8'h00, "R5 ack clears flag");
    stop2_exit_i = 1'b1; wr(8'h04); stop2_exit_i = 1'b0;
    rd(8'h08, 8'h08, "R5 set wins over ack");

    // R8 trip selects across reset kinds, R9 others cleared
    do_reset(0);
    wr(8'h30);
    do_reset(1);
    rd(8'hFF, 8'h30, "R8 R9 brown-out keeps trip bits only");
    do_reset(2);
    rd(8'hFF, 8'h30, "R8 R9 other reset keeps trip bits only");
    chk({6'h0, det_trip_hi_o, warn_trip_hi_o}, 8'h03, "R8 trip outputs kept");
    do_reset(0);
    rd(8'hFF, 8'h00, "R8 power-on clears trip bits");

    // R10 unselected write and read
    sel_i = 1'b0; wr_i = 1'b1; wdata_i = 8'hFF;
    tick();
    wr_i = 1'b0; wdata_i = 8'h00;
    chk(rdata_o, 8'h00, "R10 read data zero when not selected");
    rd(8'hFF, 8'h00, "R10 unselected write ignored");
    wr(8'h03);
    rd(8'h03, 8'h03, "R10 mode bits still unlocked after unselected write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule